// File: doc/BRIEF.md
# CEC Frame Mailbox Register Bank

This block is the target-side register file that sits between a host and a CEC line engine. The host reaches it with 16-bit word reads and writes, addressed by an 8-bit register index. One outgoing frame is staged from a header byte, an opcode byte, a length and up to seven data words that each pack two operand bytes. The send starts when the header register is written. One incoming frame is presented in the same split form.

Each event sets a bit in a write-one-to-clear CEC status register: a frame arrived, a receive error, a frame was sent, a send failed, no acknowledge, or an overflow. A CEC event or an external IR event also raises a bit in a global status register, but only while the matching enable bit is set. The interrupt output is high while any global bit is pending. Toward the line engine the block streams transmit bytes under a valid/ready handshake and takes a result code at the end. It also accepts received bytes with last and error flags.

Top module: `cec_mailbox`

## Requirements
- R1: After reset the version register (index 0x00) reads the parameter VERSION (default 0x0F0B). The address register (0x29) reads 0x000F, which means unregistered. Enable (0x01), global status (0x03) and CEC status (0x28) read 0, and irqOut is low.
- R2: A write to the tx header register (0x3D) starts a byte stream of length+1 bytes on txByte. The stream holds, in order, the header byte (bits [7:0] of the write), the opcode (0x34), then the operand bytes. Tx data word n (0x36+n) supplies operand byte 2n from bits [7:0] and operand byte 2n+1 from bits [15:8]. txLast marks the final byte, and a length (0x35, bits [3:0]) of 0 sends the header alone. A byte moves when txValid and txReady are both high, and txByte holds while txReady is low.
- R3: A write to the tx header register while a send is in progress is ignored and adds no bytes to the stream.
- R4: A txDone pulse after the stream ends sets CEC status bit 2 (sent). txResult 1 (failure) also sets bit 3. txResult 2 (no acknowledge) also sets bits 3 and 4. txResult 0 sets bit 2 only.
- R5: A received frame is latched when its last byte arrives and sets CEC status bit 0. The header goes to 0x33 and the opcode to 0x2A. The rx length register 0x2B holds the byte count minus one. Operand byte 2n goes to bits [7:0] and byte 2n+1 to bits [15:8] of rx data word 0x2C+n.
- R6: A frame that ends with rxErr high sets CEC status bits 0 and 1.
- R7: A frame of more than 16 bytes sets CEC status bits 0 and 5. The first 16 bytes are kept, and the rx length reads 15.
- R8: A frame that starts while status bit 0 is set is dropped. The rx registers are left unchanged, and only bit 5 is set.
- R9: Writing ones to 0x28 clears those CEC status bits. Writing ones to bits 12 and 13 of 0x03 clears those global bits.
- R10: Global bit 12 sets on any CEC status event only while enable bit 12 is 1. Global bit 13 sets on an irEvent pulse only while enable bit 13 is 1.
- R11: irqOut is high exactly while a global status bit is set, so an event after a clear gives a new rising edge.
- R12: The address register keeps bits [3:0] of a write and reads 0 in bits [15:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register index |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| irqOut | output | 1 | Interrupt, high while a global bit is pending |
| irEvent | input | 1 | IR event pulse |
| txValid | output | 1 | Transmit byte valid |
| txByte | output | 8 | Transmit byte |
| txLast | output | 1 | Final byte of the frame |
| txReady | input | 1 | Line engine takes the byte |
| txDone | input | 1 | Transmission finished pulse |
| txResult | input | 2 | 0 ok, 1 failure, 2 no acknowledge |
| rxValid | input | 1 | Received byte valid |
| rxByte | input | 8 | Received byte |
| rxLast | input | 1 | Final received byte |
| rxErr | input | 1 | Frame received with error (valid with rxLast) |

## Verification
Register reads are combinational, so a register write or status event sampled at a rising edge is visible at the next falling edge. The bench issues every read and check at a falling edge after the edge that causes the change. Transmit bytes appear the cycle after the header write, and each moves at the edge where txValid and txReady are both high. A monitor at the falling edge compares the presented byte and last flag against a queue whenever the handshake will complete at the coming edge. Status bits and irqOut change at the edge that samples the last received byte, a txDone pulse or an irEvent pulse, and are checked one half cycle later.

// File: rtl/cec_mbx_pkg.sv
package cec_mbx_pkg;
  localparam logic [7:0] ADR_VER   = 8'h00;
  localparam logic [7:0] ADR_EN    = 8'h01;
  localparam logic [7:0] ADR_GSTAT = 8'h03;
  localparam logic [7:0] ADR_CSTAT = 8'h28;
  localparam logic [7:0] ADR_LA    = 8'h29;
  localparam logic [7:0] ADR_RXOP  = 8'h2A;
  localparam logic [7:0] ADR_RXLEN = 8'h2B;
  localparam logic [7:0] ADR_RXD0  = 8'h2C;
  localparam logic [7:0] ADR_RXHDR = 8'h33;
  localparam logic [7:0] ADR_TXOP  = 8'h34;
  localparam logic [7:0] ADR_TXLEN = 8'h35;
  localparam logic [7:0] ADR_TXD0  = 8'h36;
  localparam logic [7:0] ADR_TXHDR = 8'h3D;

  localparam int DATA_WORDS = 7;
  localparam int DATA_BYTES = 2 * DATA_WORDS;
  localparam int FRAME_MAX  = DATA_BYTES + 2;

  typedef enum logic [1:0] {RES_OK = 2'd0, RES_FAIL = 2'd1, RES_NACK = 2'd2} txres_e;

  typedef struct packed {
    logic       txHdrLoad;
    logic       rxHdrLoad;
    logic       rxOpLoad;
    logic       rxDataLoad;
    logic [3:0] rxDataIdx;
    logic       rxDone;
    logic       rxErr;
    logic       rxOvf;
    logic [3:0] rxLen;
    logic       txDone;
    logic       txErr;
    logic       txNack;
  } strobe_t;
endpackage

// File: rtl/cec_mbx_ctrl.sv
module cec_mbx_ctrl
  import cec_mbx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [7:0]  regAddr,
  input  logic [3:0]  txLen,
  input  logic        rxPending,
  input  logic        txReady,
  input  logic        txDoneIn,
  input  logic [1:0]  txResult,
  input  logic        rxValid,
  input  logic        rxLast,
  input  logic        rxErrIn,
  output strobe_t     st,
  output logic [3:0]  txIdx,
  output logic        txValid,
  output logic        txLast
);
  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT} txstate_e;
  localparam logic [4:0] CNT_SAT = 5'(FRAME_MAX + 1);

  txstate_e   txState;
  logic [4:0] rxCnt;
  logic       rxDropping;
  logic       dropNow;
  logic [4:0] rxTotal;

  assign txValid = (txState == S_SEND);
  assign txLast  = (txIdx == txLen);
  assign dropNow = (rxCnt == 5'd0) ? rxPending : rxDropping;
  assign rxTotal = rxCnt + 5'd1;

  always_comb begin
    st = '0;
    st.txHdrLoad = regWr && (regAddr == ADR_TXHDR) && (txState == S_IDLE);
    if (txState == S_WAIT && txDoneIn) begin
      st.txDone = 1'b1;
      st.txErr  = (txResult != RES_OK);
      st.txNack = (txResult == RES_NACK);
    end
    st.rxDataIdx = 4'(rxCnt - 5'd2);
    if (rxValid && !dropNow) begin
      st.rxHdrLoad  = (rxCnt == 5'd0);
      st.rxOpLoad   = (rxCnt == 5'd1);
      st.rxDataLoad = (rxCnt >= 5'd2) && (rxCnt < 5'(FRAME_MAX));
    end
    if (rxValid && rxLast) begin
      if (dropNow) begin
        st.rxOvf = 1'b1;
      end else begin
        st.rxDone = 1'b1;
        st.rxErr  = rxErrIn;
        st.rxOvf  = (rxTotal > 5'(FRAME_MAX));
        st.rxLen  = (rxTotal > 5'(FRAME_MAX)) ? 4'hF : 4'(rxTotal - 5'd1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= S_IDLE;
      txIdx   <= '0;
    end else begin
      case (txState)
        S_IDLE: if (st.txHdrLoad) begin
          txState <= S_SEND;
          txIdx   <= '0;
        end
        S_SEND: if (txReady) begin
          if (txLast) txState <= S_WAIT;
          else        txIdx   <= txIdx + 4'd1;
        end
        S_WAIT: if (txDoneIn) txState <= S_IDLE;
        default: txState <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxCnt      <= '0;
      rxDropping <= 1'b0;
    end else if (rxValid) begin
      if (rxLast) begin
        rxCnt      <= '0;
        rxDropping <= 1'b0;
      end else begin
        rxCnt <= (rxCnt == CNT_SAT) ? CNT_SAT : rxCnt + 5'd1;
        if (rxCnt == 5'd0) rxDropping <= rxPending;
      end
    end
  end
endmodule

// File: rtl/cec_mbx_regs.sv
module cec_mbx_regs
  import cec_mbx_pkg::*;
#(
  parameter logic [15:0] VERSION = 16'h0F0B
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [7:0]  regAddr,
  input  logic [15:0] regWrData,
  input  logic        irEvent,
  input  strobe_t     st,
  input  logic [3:0]  txIdx,
  input  logic [7:0]  rxByte,
  output logic [15:0] regRdData,
  output logic [7:0]  txByte,
  output logic [3:0]  txLen,
  output logic        rxPending,
  output logic        irqOut,
  output logic [1:0]  enableBits,
  output logic [1:0]  globalStat,
  output logic [5:0]  cecStat
);
  logic [7:0] txHdr, txOp, rxHdr, rxOp;
  logic [3:0] rxLenR, laReg;
  logic [7:0] txBytes [DATA_BYTES];
  logic [7:0] rxBytes [DATA_BYTES];
  logic [5:0] cSet, cClr;
  logic [1:0] gSet, gClr;

  assign cSet = {st.rxOvf, st.txNack, st.txErr, st.txDone, st.rxErr, st.rxDone};
  assign cClr = (regWr && regAddr == ADR_CSTAT) ? regWrData[5:0] : 6'd0;
  assign gSet = {irEvent & enableBits[1], (|cSet) & enableBits[0]};
  assign gClr = (regWr && regAddr == ADR_GSTAT) ? regWrData[13:12] : 2'd0;

  assign rxPending = cecStat[0];
  assign irqOut    = |globalStat;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableBits <= '0;
      globalStat <= '0;
      cecStat    <= '0;
      laReg      <= 4'hF;
      txHdr      <= '0;
      txOp       <= '0;
      txLen      <= '0;
      rxHdr      <= '0;
      rxOp       <= '0;
      rxLenR     <= '0;
      for (int i = 0; i < DATA_BYTES; i++) begin
        txBytes[i] <= '0;
        rxBytes[i] <= '0;
      end
    end else begin
      cecStat    <= (cecStat & ~cClr) | cSet;
      globalStat <= (globalStat & ~gClr) | gSet;
      if (regWr) begin
        if (regAddr == ADR_EN)    enableBits <= regWrData[13:12];
        if (regAddr == ADR_LA)    laReg      <= regWrData[3:0];
        if (regAddr == ADR_TXOP)  txOp       <= regWrData[7:0];
        if (regAddr == ADR_TXLEN) txLen      <= regWrData[3:0];
        for (int w = 0; w < DATA_WORDS; w++) begin
          if (regAddr == ADR_TXD0 + 8'(w)) begin
            txBytes[2*w]   <= regWrData[7:0];
            txBytes[2*w+1] <= regWrData[15:8];
          end
        end
      end
      if (st.txHdrLoad)  txHdr <= regWrData[7:0];
      if (st.rxHdrLoad)  rxHdr <= rxByte;
      if (st.rxOpLoad)   rxOp  <= rxByte;
      if (st.rxDataLoad) rxBytes[st.rxDataIdx] <= rxByte;
      if (st.rxDone)     rxLenR <= st.rxLen;
    end
  end

  always_comb begin
    if (txIdx == 4'd0)      txByte = txHdr;
    else if (txIdx == 4'd1) txByte = txOp;
    else                    txByte = txBytes[txIdx - 4'd2];
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADR_VER:   regRdData = VERSION;
      ADR_EN:    regRdData = {2'b00, enableBits, 12'h000};
      ADR_GSTAT: regRdData = {2'b00, globalStat, 12'h000};
      ADR_CSTAT: regRdData = {10'd0, cecStat};
      ADR_LA:    regRdData = {12'd0, laReg};
      ADR_RXOP:  regRdData = {8'd0, rxOp};
      ADR_RXLEN: regRdData = {12'd0, rxLenR};
      ADR_RXHDR: regRdData = {8'd0, rxHdr};
      ADR_TXOP:  regRdData = {8'd0, txOp};
      ADR_TXLEN: regRdData = {12'd0, txLen};
      ADR_TXHDR: regRdData = {8'd0, txHdr};
      default: begin
        for (int w = 0; w < DATA_WORDS; w++) begin
          if (regAddr == ADR_RXD0 + 8'(w)) regRdData = {rxBytes[2*w+1], rxBytes[2*w]};
          if (regAddr == ADR_TXD0 + 8'(w)) regRdData = {txBytes[2*w+1], txBytes[2*w]};
        end
      end
    endcase
  end
endmodule

// File: rtl/cec_mailbox.sv
module cec_mailbox
  import cec_mbx_pkg::*;
#(
  parameter logic [15:0] VERSION = 16'h0F0B
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [7:0]  regAddr,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  output logic        irqOut,
  input  logic        irEvent,
  output logic        txValid,
  output logic [7:0]  txByte,
  output logic        txLast,
  input  logic        txReady,
  input  logic        txDone,
  input  logic [1:0]  txResult,
  input  logic        rxValid,
  input  logic [7:0]  rxByte,
  input  logic        rxLast,
  input  logic        rxErr
);
  strobe_t    st;
  logic [3:0] txIdx, txLen;
  logic       rxPending;
  logic [1:0] enableBits, globalStat;
  logic [5:0] cecStat;

  cec_mbx_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .txLen(txLen), .rxPending(rxPending), .txReady(txReady),
    .txDoneIn(txDone), .txResult(txResult), .rxValid(rxValid),
    .rxLast(rxLast), .rxErrIn(rxErr), .st(st), .txIdx(txIdx),
    .txValid(txValid), .txLast(txLast)
  );

  cec_mbx_regs #(.VERSION(VERSION)) uRegs (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .irEvent(irEvent), .st(st), .txIdx(txIdx),
    .rxByte(rxByte), .regRdData(regRdData), .txByte(txByte),
    .txLen(txLen), .rxPending(rxPending), .irqOut(irqOut),
    .enableBits(enableBits), .globalStat(globalStat), .cecStat(cecStat)
  );
endmodule

// File: rtl/cec_mailbox_checker.sv
module cec_mailbox_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regWr,
  input logic [7:0] regAddr,
  input logic       irqOut,
  input logic       irEvent,
  input logic       txValid,
  input logic [7:0] txByte,
  input logic       txReady,
  input logic       txDone,
  input logic [1:0] txResult,
  input logic       rxValid,
  input logic       rxLast,
  input logic [1:0] enableBits,
  input logic [1:0] globalStat,
  input logic [5:0] cecStat
);
  AST_TX_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txValid) |-> $past(regWr && regAddr == 8'h3D)); // R2
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txByte))); // R2
  AST_TXERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cecStat[3]) |-> $past(txDone && txResult != 2'd0)); // R4
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cecStat[5]) |-> $past(rxValid && rxLast)); // R7
  AST_GLOBAL_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(globalStat[0]) |-> $past(enableBits[0])); // R10
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(txDone || (rxValid && rxLast) || irEvent)); // R11
endmodule

bind cec_mailbox cec_mailbox_checker uChk (
  .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .irqOut(irqOut),
  .irEvent(irEvent), .txValid(txValid), .txByte(txByte), .txReady(txReady),
  .txDone(txDone), .txResult(txResult), .rxValid(rxValid), .rxLast(rxLast),
  .enableBits(enableBits), .globalStat(globalStat), .cecStat(cecStat)
);

// File: tb/cec_mailbox_test.sv
module cec_mailbox_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irqOut, irEvent = 1'b0;
  logic        txValid, txLast, txReady = 1'b0;
  logic [7:0]  txByte;
  logic        txDone = 1'b0;
  logic [1:0]  txResult = '0;
  logic        rxValid = 1'b0, rxLast = 1'b0, rxErr = 1'b0;
  logic [7:0]  rxByte = '0;

  int checks = 0, failures = 0;
  logic [8:0] txQ[$];
  logic [1:0] readyCnt = '0;
  logic [7:0] frm [18];

  always #10 clk = ~clk;

  cec_mailbox uut (.*);

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: handshake completes at the coming rising edge.
  always @(negedge clk) begin
    if (rstN && txValid && txReady) begin
      checks++;
      if (txQ.size() == 0) begin
        failures++;
        $display("FAIL R3 unexpected tx byte actual=%h expected=none", txByte);
      end else begin
        logic [8:0] e;
        e = txQ.pop_front();
        if ({txLast, txByte} !== e) begin
          failures++;
          $display("FAIL R2 tx byte actual=%h expected=%h", {txLast, txByte}, e);
        end
      end
    end
    readyCnt <= readyCnt + 2'd1;
    txReady  <= readyCnt[0] | readyCnt[1];
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  // Driver: stage frame frm[0..len], push expected bytes, launch, finish with result.
  task automatic sendFrame(input int len, input logic [1:0] res, input bit retrigger);
    wr(8'h34, {8'h00, frm[1]});
    wr(8'h35, 16'(len));
    for (int w = 0; w < 7; w++) wr(8'h36 + 8'(w), {frm[2*w+3], frm[2*w+2]});
    for (int i = 0; i <= len; i++) txQ.push_back({i == len, frm[i]});
    wr(8'h3D, {8'h00, frm[0]});
    if (retrigger) wr(8'h3D, 16'h00EE);
    wait (txQ.size() == 0);
    @(negedge clk); @(negedge clk);
    txResult = res; txDone = 1'b1;
    @(negedge clk);
    txDone = 1'b0;
  endtask

  task automatic recvFrame(input int n, input bit err);
    for (int i = 0; i < n; i++) begin
      rxValid = 1'b1; rxByte = frm[i]; rxLast = (i == n - 1); rxErr = err && (i == n - 1);
      @(negedge clk);
    end
    rxValid = 1'b0; rxLast = 1'b0; rxErr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, v); check("R1 version", v, 16'h0F0B);
    rd(8'h29, v); check("R1 address", v, 16'h000F);
    rd(8'h28, v); check("R1 cec status", v, 16'h0000);
    rd(8'h03, v); check("R1 global", v, 16'h0000);
    rd(8'h01, v); check("R1 enable", v, 16'h0000);
    check("R1 irq", {15'd0, irqOut}, 16'h0000);
    // R12 address register
    wr(8'h29, 16'hABC5);
    rd(8'h29, v); check("R12 address", v, 16'h0005);

    // R2 R3 R4 R10: six-byte frame, retrigger ignored, ok result, CEC not enabled
    frm[0] = 8'h40; frm[1] = 8'h82; frm[2] = 8'h11; frm[3] = 8'h22;
    frm[4] = 8'h33; frm[5] = 8'h44;
    for (int i = 6; i < 16; i++) frm[i] = 8'(i);
    sendFrame(5, 2'd0, 1'b1);
    rd(8'h28, v); check("R4 sent ok", v, 16'h0004);
    rd(8'h03, v); check("R10 global masked", v, 16'h0000);
    check("R11 irq low when masked", {15'd0, irqOut}, 16'h0000);
    check("R3 no restart", {15'd0, txValid}, 16'h0000);
    wr(8'h28, 16'h003F);
    rd(8'h28, v); check("R9 cec clear", v, 16'h0000);

    // R2 header-only, failure result, CEC enabled
    wr(8'h01, 16'h1000);
    frm[0] = 8'h4F;
    sendFrame(0, 2'd1, 1'b0);
    rd(8'h28, v); check("R4 fail", v, 16'h000C);
    rd(8'h03, v); check("R10 global cec", v, 16'h1000);
    check("R11 irq high", {15'd0, irqOut}, 16'h0001);
    wr(8'h28, 16'h003F);
    wr(8'h03, 16'h1000);
    rd(8'h03, v); check("R9 global clear", v, 16'h0000);
    check("R11 irq low after clear", {15'd0, irqOut}, 16'h0000);

    // R4 no acknowledge, full 14 operand bytes
    for (int i = 0; i < 16; i++) frm[i] = 8'hA0 + 8'(i);
    sendFrame(15, 2'd2, 1'b0);
    rd(8'h28, v); check("R4 nack", v, 16'h001C);
    check("R11 new rising edge", {15'd0, irqOut}, 16'h0001);
    wr(8'h28, 16'h003F); wr(8'h03, 16'h3000);

    // R10 IR
    irEvent = 1'b1; @(negedge clk); irEvent = 1'b0;
    rd(8'h03, v); check("R10 ir masked", v, 16'h0000);
    wr(8'h01, 16'h3000);
    irEvent = 1'b1; @(negedge clk); irEvent = 1'b0;
    rd(8'h03, v); check("R10 ir enabled", v, 16'h2000);
    wr(8'h03, 16'h2000);

    // R5 receive
    frm[0] = 8'h0F; frm[1] = 8'h87; frm[2] = 8'hAA; frm[3] = 8'hBB; frm[4] = 8'hCC;
    recvFrame(5, 1'b0);
    rd(8'h28, v); check("R5 received", v, 16'h0001);
    rd(8'h33, v); check("R5 header", v, 16'h000F);
    rd(8'h2A, v); check("R5 opcode", v, 16'h0087);
    rd(8'h2B, v); check("R5 length", v, 16'h0004);
    rd(8'h2C, v); check("R5 word0", v, 16'hBBAA);
    rd(8'h2D, v); check("R5 word1", v, 16'h00CC);

    // R8 dropped while pending
    frm[0] = 8'h55; frm[1] = 8'h66; frm[2] = 8'h77;
    recvFrame(3, 1'b0);
    rd(8'h28, v); check("R8 drop status", v, 16'h0021);
    rd(8'h33, v); check("R8 header kept", v, 16'h000F);
    rd(8'h2B, v); check("R8 length kept", v, 16'h0004);
    wr(8'h28, 16'h003F);

    // R6 error frame
    frm[0] = 8'h10; frm[1] = 8'h44; frm[2] = 8'h55;
    recvFrame(3, 1'b1);
    rd(8'h28, v); check("R6 error status", v, 16'h0003);
    rd(8'h2B, v); check("R6 length", v, 16'h0002);
    rd(8'h2C, v); check("R6 word0", v, 16'hBB55);
    wr(8'h28, 16'h003F);

    // R7 overflow, 18 bytes
    for (int i = 0; i < 18; i++) frm[i] = 8'h10 + 8'(i);
    recvFrame(18, 1'b0);
    rd(8'h28, v); check("R7 overflow status", v, 16'h0021);
    rd(8'h2B, v); check("R7 length", v, 16'h000F);
    rd(8'h33, v); check("R7 header", v, 16'h0010);
    rd(8'h32, v); check("R7 word6", v, 16'h1F1E);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule